// File: doc/BRIEF.md
# Edge-Selectable Interrupt Request Controller

This block gathers fifteen interrupt sources for a small CPU core into two byte-wide request registers. Each request register has a byte-wide enable register beside it. Eleven sources are on-chip peripherals that deliver single-cycle pulses. The other four are external pins that arrive as asynchronous levels. Each pin passes through a two-stage synchronizer. A per-pin polarity bit then picks whether a falling or a rising edge counts as an event.

Software reaches the block through a byte-wide register port with a 3-bit address. Writes take effect on the clock edge, and reads are combinational. The block drives one combined interrupt line to the core. That line is gated by a global disable input that comes from the core's status flag. The block also exposes a 15-bit pending vector, so that an outside priority encoder can pick a vector. Because each pin is qualified by its polarity before edge detection, rewriting a polarity bit can itself look like an edge and latch a request. Software has to mask the source around such a change.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` and `pending_o` are 0.
- R2: Addresses select registers as follows: 0 = polarity, 1 = request bank A, 2 = request bank B, 3 = enable bank A, 4 = enable bank B. Addresses 5 to 7 read 0, and writes to them change no register.
- R3: A pulse on `periph_evt_i` sets its request bit at the next clock edge. The bit mapping is: index 0 to 5 → bank A bits 2 to 7 (serial receive, serial transmit, timer X, timer Y, timer 2, timer 3); index 6, 7, 8 → bank B bits 0, 1, 2 (counter input 0, counter input 1, timer 1); index 9, 10 → bank B bits 5, 6 (key input, conversion done).
- R4: A request bit stays at 1 until software writes 0 to it. Writing 1 to a request bit leaves that bit unchanged.
- R5: If a source event and a software clear hit the same request bit in the same cycle, the bit ends at 1.
- R6: Pin k uses polarity bit k. A value of 0 selects the falling edge and 1 selects the rising edge. The pins map to bank A bits 0 and 1 (pins 0, 1) and bank B bits 3 and 4 (pins 2, 3). An edge on a pin sets its request bit on the third clock edge after the change. The opposite edge sets nothing.
- R7: With a pin held low, changing its polarity bit from 1 to 0 latches that pin's request. Changing it from 0 to 1 latches nothing.
- R8: Polarity bits 7 to 4, request bank B bit 7 and enable bank B bit 7 always read 0.
- R9: `pending_o` is the bitwise AND of the requests and enables. Bits 7:0 come from bank A and bits 14:8 from bank B bits 6:0. `irq_o` is 1 exactly when some pending bit is 1 and `global_dis_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 4 | Asynchronous external interrupt pins |
| periph_evt_i | input | 11 | Single-cycle peripheral event pulses |
| global_dis_i | input | 1 | Global interrupt disable flag from the core |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pending_o | output | 15 | Requests qualified by their enables |
| irq_o | output | 1 | Combined interrupt to the core |

## Verification
A request bit that is dropped or stuck shows up on the very next read of its bank, and on `pending_o` in the same cycle. A wrong polarity or a broken synchronizer stage shows up as a request that arrives one edge early, one edge late, or never. The bench therefore samples the request registers cycle by cycle around each pin change, not only after a settling wait. A bad prior-level reset or a missing qualification step shows up as a spurious request right after a polarity write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned ADDR_W     = 3;
   localparam int unsigned NUM_PINS   = 4;
   localparam int unsigned NUM_PERIPH = 11;
   localparam int unsigned NUM_SRC    = 15;

   typedef enum logic [ADDR_W-1:0] {
      A_POL  = 3'd0,
      A_REQA = 3'd1,
      A_REQB = 3'd2,
      A_ENA  = 3'd3,
      A_ENB  = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic pol_i,
   output logic evt_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_pin_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   // qualified level: 1 means "pin at its active side"
   assign lvl = pol_i ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

   // reset value matches a low pin with falling polarity, so no event at start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b1;
      else        lvl_q <= lvl;
   end

   assign evt_o = lvl & ~lvl_q;

   // R6
   evt_needs_prior_inactive_chk : assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o || $changed(lvl_q) || !$past(evt_o));
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
   parameter int unsigned        WIDTH     = 8,
   parameter logic [WIDTH-1:0]   USED_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             req_wr_i,
   input  logic             en_wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] req_o,
   output logic [WIDTH-1:0] en_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irq_req_bank: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] req_q, en_q;
   logic [WIDTH-1:0] req_keep;

   // software can only clear; events win over a same-cycle clear
   assign req_keep = req_wr_i ? (req_q & wdata_i) : req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         en_q  <= '0;
      end else begin
         req_q <= (req_keep | set_i) & USED_MASK;
         if (en_wr_i) en_q <= wdata_i & USED_MASK;
      end
   end

   assign req_o = req_q;
   assign en_o  = en_q;

   // R3
   evt_latch_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & USED_MASK)) |=> ((req_o & $past(set_i & USED_MASK)) == $past(set_i & USED_MASK)));
   // R4
   sticky_req_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !req_wr_i |=> ((req_o & $past(req_o)) == $past(req_o)));
   // R4
   no_sw_set_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0) |=> ((req_o & ~$past(req_o)) == '0));
   // R8
   unused_bits_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ((req_o | en_o) & ~USED_MASK) == '0);
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   ext_pin_i,
   input  logic [NUM_PERIPH-1:0] periph_evt_i,
   input  logic                  global_dis_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [BYTE_W-1:0]     wdata_i,
   output logic [BYTE_W-1:0]     rdata_o,
   output logic [NUM_SRC-1:0]    pending_o,
   output logic                  irq_o
);
   localparam logic [BYTE_W-1:0] MASK_A = 8'hFF;
   localparam logic [BYTE_W-1:0] MASK_B = 8'h7F;

   generate
      if (NUM_PINS != 4 || NUM_PERIPH != 11 || NUM_SRC != 15) begin : g_bad_map
         $error("irq_edge_ctrl: source map is built for 4 pins and 11 peripherals");
      end
   endgenerate

   logic [NUM_PINS-1:0] pol_q;
   logic [NUM_PINS-1:0] pin_evt;
   logic [BYTE_W-1:0]   set_a, set_b;
   logic [BYTE_W-1:0]   req_a, req_b, en_a, en_b;
   logic                wr_pol, wr_req_a, wr_req_b, wr_en_a, wr_en_b;

   assign wr_pol   = wr_en_i && (addr_i == A_POL);
   assign wr_req_a = wr_en_i && (addr_i == A_REQA);
   assign wr_req_b = wr_en_i && (addr_i == A_REQB);
   assign wr_en_a  = wr_en_i && (addr_i == A_ENA);
   assign wr_en_b  = wr_en_i && (addr_i == A_ENB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pol_q <= '0;
      else if (wr_pol) pol_q <= wdata_i[NUM_PINS-1:0];
   end

   genvar gp;
   generate
      for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
         irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (ext_pin_i[gp]),
            .pol_i (pol_q[gp]),
            .evt_o (pin_evt[gp])
         );
      end
   endgenerate

   // source placement; pins 2,3 sit between peripheral groups in bank B
   assign set_a = {periph_evt_i[5:0], pin_evt[1:0]};
   assign set_b = {1'b0, periph_evt_i[10:9], pin_evt[3:2], periph_evt_i[8:6]};

   irq_req_bank #(.WIDTH(BYTE_W), .USED_MASK(MASK_A)) u_bank_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_a),
      .req_wr_i (wr_req_a),
      .en_wr_i  (wr_en_a),
      .wdata_i  (wdata_i),
      .req_o    (req_a),
      .en_o     (en_a)
   );

   irq_req_bank #(.WIDTH(BYTE_W), .USED_MASK(MASK_B)) u_bank_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_b),
      .req_wr_i (wr_req_b),
      .en_wr_i  (wr_en_b),
      .wdata_i  (wdata_i),
      .req_o    (req_b),
      .en_o     (en_b)
   );

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_POL:   rdata_o[NUM_PINS-1:0] = pol_q;
         A_REQA:  rdata_o = req_a;
         A_REQB:  rdata_o = req_b;
         A_ENA:   rdata_o = en_a;
         A_ENB:   rdata_o = en_b;
         default: rdata_o = '0;
      endcase
   end

   assign pending_o = {req_b[6:0] & en_b[6:0], req_a & en_a};
   assign irq_o     = (|pending_o) & ~global_dis_i;

   // R9
   irq_gated_chk : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !global_dis_i);
   // R9
   pending_needs_req_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ((pending_o & ~{req_b[6:0], req_a}) == '0));
   // R2
   pol_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pol |=> $stable(pol_q));
endmodule

// File: tb/irq_edge_ctrl_tb_top.sv
module irq_edge_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ext_pin_i = '0;
   logic [10:0] periph_evt_i = '0;
   logic        global_dis_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  addr_i = '0;
   logic [7:0]  wdata_i = '0;
   logic [7:0]  rdata_o;
   logic [14:0] pending_o;
   logic        irq_o;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_edge_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .periph_evt_i(periph_evt_i),
      .global_dis_i(global_dis_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .pending_o(pending_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
      addr_i = a;
      #1;
      check(req, {24'd0, rdata_o}, {24'd0, exp});
   endtask

   task automatic pulse(input logic [10:0] e);
      @(negedge clk);
      periph_evt_i = e;
      @(negedge clk);
      periph_evt_i = '0;
   endtask

   task automatic clean();
      wr(3'd0, 8'h00);
      repeat (3) @(negedge clk);
      wr(3'd1, 8'h00); wr(3'd2, 8'h00);
      wr(3'd3, 8'h00); wr(3'd4, 8'h00);
   endtask

   task automatic t_reset();
      for (int a = 0; a < 8; a++) rd_check("R1 reg", a[2:0], 8'h00);
      check("R1 irq", {31'd0, irq_o}, 32'd0);
      check("R1 pending", {17'd0, pending_o}, 32'd0);
   endtask

   task automatic t_regmap();
      wr(3'd3, 8'hA5); wr(3'd4, 8'h5A); wr(3'd0, 8'h0A);
      rd_check("R2 enA", 3'd3, 8'hA5);
      rd_check("R2 enB", 3'd4, 8'h5A);
      rd_check("R2 pol", 3'd0, 8'h0A);
      wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
      rd_check("R2 addr5", 3'd5, 8'h00);
      rd_check("R2 addr7", 3'd7, 8'h00);
      rd_check("R2 enA kept", 3'd3, 8'hA5);
      rd_check("R2 pol kept", 3'd0, 8'h0A);
      clean();
   endtask

   task automatic t_periph();
      pulse(11'h001);
      rd_check("R3 srx", 3'd1, 8'h04);
      clean();
      pulse(11'h7FF);
      rd_check("R3 bankA", 3'd1, 8'hFC);
      rd_check("R3 bankB", 3'd2, 8'h67);
      clean();
   endtask

   task automatic t_sticky();
      pulse(11'h004);
      repeat (5) @(negedge clk);
      rd_check("R4 held", 3'd1, 8'h10);
      wr(3'd1, 8'hFF);
      rd_check("R4 write1 no effect", 3'd1, 8'h10);
      wr(3'd1, 8'hEF);
      rd_check("R4 cleared", 3'd1, 8'h00);
      clean();
   endtask

   task automatic t_race();
      pulse(11'h001);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h00; periph_evt_i = 11'h001;
      @(negedge clk);
      wr_en_i = 1'b0; periph_evt_i = '0;
      rd_check("R5 event wins", 3'd1, 8'h04);
      clean();
   endtask

   task automatic t_pins();
      // pin0 falling (pol 0): rising edge ignored
      @(negedge clk); ext_pin_i[0] = 1'b1;
      repeat (5) @(negedge clk);
      rd_check("R6 rise ignored", 3'd1, 8'h00);
      @(negedge clk); ext_pin_i[0] = 1'b0;
      @(negedge clk); @(negedge clk);
      rd_check("R6 latency early", 3'd1, 8'h00);
      @(negedge clk);
      rd_check("R6 pin0 fall", 3'd1, 8'h01);
      // pin2 rising
      wr(3'd0, 8'h04);
      repeat (3) @(negedge clk);
      rd_check("R6 pol up no req", 3'd2, 8'h00);
      @(negedge clk); ext_pin_i[2] = 1'b1;
      repeat (4) @(negedge clk);
      rd_check("R6 pin2 rise", 3'd2, 8'h08);
      // pin3 falling
      @(negedge clk); ext_pin_i[3] = 1'b1;
      repeat (4) @(negedge clk);
      rd_check("R6 pin3 rise ignored", 3'd2, 8'h08);
      @(negedge clk); ext_pin_i[3] = 1'b0;
      repeat (4) @(negedge clk);
      rd_check("R6 pin3 fall", 3'd2, 8'h18);
      // pin1 rising
      wr(3'd0, 8'h06);
      @(negedge clk); ext_pin_i[1] = 1'b1;
      repeat (4) @(negedge clk);
      rd_check("R6 pin1 rise", 3'd1, 8'h03);
      ext_pin_i = '0;
      repeat (4) @(negedge clk);
      clean();
   endtask

   task automatic t_polswitch();
      wr(3'd0, 8'h01);
      repeat (2) @(negedge clk);
      rd_check("R7 0to1 no req", 3'd1, 8'h00);
      wr(3'd0, 8'h00);
      @(negedge clk);
      rd_check("R7 1to0 spurious", 3'd1, 8'h01);
      clean();
   endtask

   task automatic t_unused();
      wr(3'd0, 8'hFF);
      rd_check("R8 pol hi", 3'd0, 8'h0F);
      wr(3'd4, 8'hFF);
      rd_check("R8 enB b7", 3'd4, 8'h7F);
      pulse(11'h7FF);
      rd_check("R8 reqB b7", 3'd2, 8'h67);
      ext_pin_i = '0;
      clean();
   endtask

   task automatic t_irq();
      pulse(11'h004);
      #1;
      check("R9 no enable", {31'd0, irq_o}, 32'd0);
      wr(3'd3, 8'h10);
      #1;
      check("R9 pending A", {17'd0, pending_o}, 32'h0010);
      check("R9 irq on", {31'd0, irq_o}, 32'd1);
      global_dis_i = 1'b1; #1;
      check("R9 masked", {31'd0, irq_o}, 32'd0);
      global_dis_i = 1'b0;
      pulse(11'h200);
      wr(3'd4, 8'h20);
      #1;
      check("R9 pending B", {17'd0, pending_o}, 32'h2010);
      wr(3'd3, 8'h00); wr(3'd4, 8'h00);
      #1;
      check("R9 irq off", {31'd0, irq_o}, 32'd0);
      clean();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_periph();
      t_sticky();
      t_race();
      t_pins();
      t_polswitch();
      t_unused();
      t_irq();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule